// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This unit turns one multi-register memory transfer request into a series of single-word transfers. A request carries a base address, a mask that selects up to sixteen registers, an addressing mode and a writeback enable. The request is accepted through a valid/ready start handshake. For every selected register the unit presents a register index and a word address on a valid/ready transfer port. Registers are visited in ascending index order, and the address climbs by one word per accepted transfer.

The first address depends on how many registers are selected and on the mode. Two modes walk upward from the base and two walk downward. After the last transfer has been accepted, a one-cycle completion pulse carries three things: the updated base value, whether that base should be written back, and whether the top register (the program counter) was in the mask. A new request may be accepted in the same cycle as the completion pulse, so block transfers can run back to back.

Top module: `lsm_seq`

## Requirements
- R1: The unit issues one accepted transfer per set bit of `reg_list` and no more. The register indices appear in strictly ascending order, and each index names a bit that is set in the mask.
- R2: Let n be the number of set bits. The first transfer address depends on the mode encoding: 0 gives base; 1 gives base+4; 2 gives base-4n+4; 3 gives base-4n. All address arithmetic wraps modulo 2^32.
- R3: Each transfer accepted on the port (valid and ready both high at a clock edge) raises the next transfer address by 4.
- R4: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_idx` and `xfer_addr` hold their values into the next cycle.
- R5: `done` is high for the one cycle that follows the edge at which the last transfer was accepted. With an empty mask, no transfer is issued and `done` is high in the cycle after the start is accepted. `done` and `xfer_valid` are never high together.
- R6: While `done` is high, `wb_value` equals base+4n for modes 0 and 1 and base-4n for modes 2 and 3. In the same cycle `wb_valid` equals the request's `wb_en`, and `wb_valid` is low whenever `done` is low.
- R7: While `done` is high, `pc_loaded` equals bit 15 of the request's mask. It is low whenever `done` is low.
- R8: `start_ready` is high when the unit is idle and in the `done` cycle, and low while transfers are outstanding. A start accepted in the `done` cycle begins the new request without an idle cycle between them.
- R9: After synchronous reset, `start_ready` is 1 and `xfer_valid`, `done`, `wb_valid` and `pc_loaded` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Request can be accepted this cycle |
| base_addr | input | 32 | Base address of the request |
| reg_list | input | 16 | Register selection mask |
| mode | input | 2 | Addressing mode (0 up-after, 1 up-before, 2 down-after, 3 down-before) |
| wb_en | input | 1 | Base writeback requested |
| xfer_valid | output | 1 | Word transfer present |
| xfer_ready | input | 1 | Word transfer accepted |
| xfer_idx | output | 4 | Register index of the transfer |
| xfer_addr | output | 32 | Word address of the transfer |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Base writeback requested, qualified by done |
| wb_value | output | 32 | New base value |
| pc_loaded | output | 1 | Register 15 was in the mask, qualified by done |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench provokes this by presenting a fresh request exactly in the cycle where it sees `done`. It then checks that `start_ready` is high, that the old request's writeback and program-counter flags are still correct, and that the next cycle shows the new request's first address, or a fresh `done` if the new mask is empty. Random stalls on `xfer_ready` also let the last acceptance of a request coincide with a transfer of register 15. In that case the bench checks that the completion pulse still follows exactly one cycle later.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int unsigned LSM_ADDR_W = 32;
    localparam int unsigned LSM_NREG   = 16;
    localparam int unsigned LSM_BYTES  = 4;

    typedef enum logic [1:0] {
        AM_UP_AFTER   = 2'd0,
        AM_UP_BEFORE  = 2'd1,
        AM_DOWN_AFTER = 2'd2,
        AM_DOWN_BEFORE = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_MOVE = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_e;

    // Downward modes place the block below the base.
    function automatic logic mode_down(amode_e m);
        return m[1];
    endfunction

    // Modes whose first word sits one word above the lowest block address.
    function automatic logic mode_skip_word(amode_e m);
        return m[1] ^ m[0];
    endfunction

endpackage

// File: rtl/lsm_plan.sv
module lsm_plan
    import lsm_pkg::*;
#(
    parameter int unsigned ADDR_W = LSM_ADDR_W,
    parameter int unsigned NREG   = LSM_NREG,
    parameter int unsigned BYTES  = LSM_BYTES
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   mask,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int unsigned CNT_W = $clog2(NREG + 1);

    amode_e              am;
    logic [CNT_W-1:0]    cnt;
    logic [ADDR_W-1:0]   span;
    logic [ADDR_W-1:0]   low;

    assign am = amode_e'(mode);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end

    assign span       = ADDR_W'(cnt) * ADDR_W'(BYTES);
    assign low        = mode_down(am) ? (base - span) : base;
    assign first_addr = low + (mode_skip_word(am) ? ADDR_W'(BYTES) : '0);
    assign wb_addr    = mode_down(am) ? (base - span) : (base + span);

endmodule

// File: rtl/lsm_pick.sv
module lsm_pick
    import lsm_pkg::*;
#(
    parameter int unsigned NREG = LSM_NREG,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  pend,
    output logic [NREG-1:0]  grant,
    output logic [IDX_W-1:0] idx
);
    for (genvar g = 0; g < NREG; g++) begin : g_grant
        if (g == 0) begin : g_lowest
            assign grant[g] = pend[g];
        end else begin : g_upper
            assign grant[g] = pend[g] & ~(|pend[g-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (grant[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int unsigned ADDR_W = LSM_ADDR_W,
    parameter int unsigned NREG   = LSM_NREG,
    parameter int unsigned BYTES  = LSM_BYTES,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREG-1:0]   reg_list,
    input  logic [1:0]        mode,
    input  logic              wb_en,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [IDX_W-1:0]  xfer_idx,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              done,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value,
    output logic              pc_loaded
);
    typedef struct packed {
        sq_state_e         st;
        logic [NREG-1:0]   pend;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wbv;
        logic              wbe;
        logic              pcf;
    } seq_t;

    seq_t              q;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_wb;
    logic [NREG-1:0]   pick_grant;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pend_next;
    logic              accept;

    lsm_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .BYTES(BYTES)) u_plan (
        .base       (base_addr),
        .mask       (reg_list),
        .mode       (mode),
        .first_addr (plan_first),
        .wb_addr    (plan_wb)
    );

    lsm_pick #(.NREG(NREG)) u_pick (
        .pend  (q.pend),
        .grant (pick_grant),
        .idx   (pick_idx)
    );

    assign start_ready = (q.st != SQ_MOVE);
    assign accept      = start_valid && start_ready;
    assign pend_next   = q.pend & ~pick_grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= SQ_IDLE;
            q.pend <= '0;
            q.addr <= '0;
            q.wbv  <= '0;
            q.wbe  <= 1'b0;
            q.pcf  <= 1'b0;
        end else if (accept) begin
            q.pend <= reg_list;
            q.addr <= plan_first;
            q.wbv  <= plan_wb;
            q.wbe  <= wb_en;
            q.pcf  <= reg_list[NREG-1];
            q.st   <= (reg_list == '0) ? SQ_DONE : SQ_MOVE;
        end else begin
            case (q.st)
                SQ_MOVE: begin
                    if (xfer_ready) begin
                        q.pend <= pend_next;
                        q.addr <= q.addr + ADDR_W'(BYTES);
                        if (pend_next == '0) begin
                            q.st <= SQ_DONE;
                        end
                    end
                end
                SQ_DONE: q.st <= SQ_IDLE;
                default: q.st <= SQ_IDLE;
            endcase
        end
    end

    assign xfer_valid = (q.st == SQ_MOVE);
    assign xfer_idx   = pick_idx;
    assign xfer_addr  = q.addr;
    assign done       = (q.st == SQ_DONE);
    assign wb_valid   = done && q.wbe;
    assign wb_value   = q.wbv;
    assign pc_loaded  = done && q.pcf;

    // R4
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready) |=>
            (xfer_valid && $stable(xfer_addr) && $stable(xfer_idx)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_ready && !start_valid) |=>
            (!xfer_valid || (xfer_addr == ADDR_W'($past(xfer_addr) + ADDR_W'(BYTES)))));

    // R1
    idx_rising_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_ready) |=> (!xfer_valid || (xfer_idx > $past(xfer_idx))));

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> $onehot(pick_grant));

    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !xfer_valid);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_ready && $onehot(q.pend)) |=> done);

endmodule

// File: tb/tb_lsm_seq.sv
module tb_lsm_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_valid;
    logic        start_ready;
    logic [31:0] base_addr;
    logic [15:0] reg_list;
    logic [1:0]  mode;
    logic        wb_en;
    logic        xfer_valid;
    logic        xfer_ready;
    logic [3:0]  xfer_idx;
    logic [31:0] xfer_addr;
    logic        done;
    logic        wb_valid;
    logic [31:0] wb_value;
    logic        pc_loaded;

    int checks = 0;
    int fails  = 0;

    // expected state of the request in flight
    logic [15:0] e_list;
    logic [15:0] e_pend;
    logic [31:0] e_first;
    logic [31:0] e_wb;
    logic        e_wbe;
    int          e_n;

    always #10 clk = ~clk;

    lsm_seq dut (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_ready(start_ready),
        .base_addr(base_addr), .reg_list(reg_list), .mode(mode), .wb_en(wb_en),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_idx(xfer_idx), .xfer_addr(xfer_addr),
        .done(done), .wb_valid(wb_valid), .wb_value(wb_value), .pc_loaded(pc_loaded)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic int pop16(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] ref_first(input logic [31:0] b, input logic [15:0] m,
                                              input logic [1:0] md);
        logic [31:0] s = 32'(pop16(m) * 4);
        case (md)
            2'd0:    return b;
            2'd1:    return b + 32'd4;
            2'd2:    return b - s + 32'd4;
            default: return b - s;
        endcase
    endfunction

    function automatic logic [31:0] ref_wb(input logic [31:0] b, input logic [15:0] m,
                                           input logic [1:0] md);
        logic [31:0] s = 32'(pop16(m) * 4);
        return md[1] ? (b - s) : (b + s);
    endfunction

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return 0;
    endfunction

    // Present a request at the current (negedge) time.
    task automatic launch(input logic [31:0] b, input logic [15:0] m,
                          input logic [1:0] md, input logic w);
        chk(start_ready == 1'b1, "R8", "start_ready at launch", 32'(start_ready), 32'd1);
        start_valid = 1'b1;
        base_addr   = b;
        reg_list    = m;
        mode        = md;
        wb_en       = w;
        e_list  = m;
        e_pend  = m;
        e_first = ref_first(b, m, md);
        e_wb    = ref_wb(b, m, md);
        e_wbe   = w;
        e_n     = pop16(m);
    endtask

    // Run the request to its completion pulse; returns at the negedge showing done.
    task automatic finish(input int stall_pct);
        int          k = 0;
        int          guard = 0;
        bit          pv = 1'b0;
        bit          pr = 1'b0;
        logic [3:0]  pidx = '0;
        logic [31:0] paddr = '0;
        @(negedge clk);
        start_valid = 1'b0;
        base_addr   = $urandom;
        reg_list    = 16'($urandom);
        if (e_n == 0) begin
            chk(done == 1'b1, "R5", "empty list done next cycle", 32'(done), 32'd1);
            chk(xfer_valid == 1'b0, "R5", "empty list no transfer", 32'(xfer_valid), 32'd0);
        end else begin
            chk(xfer_valid == 1'b1, "R2", "first transfer present", 32'(xfer_valid), 32'd1);
            chk(xfer_addr == e_first, "R2", "first address", xfer_addr, e_first);
            chk(start_ready == 1'b0, "R8", "busy start_ready", 32'(start_ready), 32'd0);
        end
        while (1) begin
            if (pv && !pr) begin
                chk(xfer_valid && xfer_idx == pidx && xfer_addr == paddr, "R4",
                    "held under stall", xfer_addr, paddr);
            end
            if (done) begin
                chk(k == e_n, "R1", "transfer count", 32'(k), 32'(e_n));
                chk(!xfer_valid, "R5", "done without transfer", 32'(xfer_valid), 32'd0);
                chk(wb_value == e_wb, "R6", "writeback value", wb_value, e_wb);
                chk(wb_valid == e_wbe, "R6", "writeback enable", 32'(wb_valid), 32'(e_wbe));
                chk(pc_loaded == e_list[15], "R7", "pc flag", 32'(pc_loaded), 32'(e_list[15]));
                chk(start_ready == 1'b1, "R8", "ready in done cycle", 32'(start_ready), 32'd1);
                return;
            end
            if (xfer_valid) begin
                if (k >= e_n) begin
                    chk(1'b0, "R1", "extra transfer", 32'(k), 32'(e_n));
                    return;
                end
                chk(32'(xfer_idx) == 32'(lowest(e_pend)), "R1", "register index",
                    32'(xfer_idx), 32'(lowest(e_pend)));
                chk(xfer_addr == e_first + 32'(4 * k), "R3", "stepped address",
                    xfer_addr, e_first + 32'(4 * k));
                chk(!wb_valid && !pc_loaded, "R7", "flags low while busy",
                    32'({wb_valid, pc_loaded}), 32'd0);
                xfer_ready = (($urandom % 100) >= stall_pct);
                pv = 1'b1; pr = xfer_ready; pidx = xfer_idx; paddr = xfer_addr;
                if (xfer_ready) begin
                    e_pend[lowest(e_pend)] = 1'b0;
                    k++;
                end
            end else begin
                chk(1'b0, "R5", "neither transfer nor done", 32'(xfer_valid), 32'd1);
                return;
            end
            guard++;
            if (guard > 2000) begin
                chk(1'b0, "R5", "no completion", 32'(guard), 32'd0);
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic one_op(input logic [31:0] b, input logic [15:0] m,
                          input logic [1:0] md, input logic w, input int stall);
        @(negedge clk);
        launch(b, m, md, w);
        finish(stall);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_valid = 1'b0; base_addr = '0; reg_list = '0;
        mode = '0; wb_en = 1'b0; xfer_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(start_ready == 1'b1, "R9", "reset start_ready", 32'(start_ready), 32'd1);
        chk({xfer_valid, done, wb_valid, pc_loaded} == 4'b0, "R9", "reset outputs",
            32'({xfer_valid, done, wb_valid, pc_loaded}), 32'd0);
        rst = 1'b0;

        // directed corner cases, one per mode
        one_op(32'h0000_1000, 16'h0000, 2'd0, 1'b1, 0);   // empty list
        one_op(32'h0000_2000, 16'hFFFF, 2'd1, 1'b1, 30);  // full list
        one_op(32'h0000_0000, 16'h8000, 2'd3, 1'b1, 50);  // only PC, wrap below zero
        one_op(32'h0000_0008, 16'h0001, 2'd2, 1'b0, 0);   // only r0
        one_op(32'h0000_0004, 16'h8421, 2'd2, 1'b1, 70);  // wrap in down-after
        one_op(32'hFFFF_FFF8, 16'h00F0, 2'd0, 1'b1, 20);  // wrap above top

        // back-to-back: new request accepted in the done cycle (R8)
        @(negedge clk);
        launch(32'h0000_4000, 16'h0006, 2'd0, 1'b1);
        finish(0);
        launch(32'h0000_5000, 16'h8003, 2'd3, 1'b0);
        finish(40);
        launch(32'h0000_6000, 16'h0000, 2'd1, 1'b1);
        finish(0);
        launch(32'h0000_7000, 16'h4000, 2'd1, 1'b1);
        finish(0);

        // constrained random
        for (int t = 0; t < 300; t++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if (t % 7 == 0) m = m & 16'($urandom) & 16'($urandom);
            if (t % 11 == 0) m = '0;
            if ((t % 2) == 1 && done) begin
                launch($urandom, m, 2'($urandom), 1'($urandom));
                finish(int'($urandom % 60));
            end else begin
                one_op($urandom, m, 2'($urandom), 1'($urandom), int'($urandom % 60));
            end
        end

        @(negedge clk);
        summary();
        $finish;
    end
endmodule